// File: doc/BRIEF.md
# Converter Result Output Formatter

This block sits between a time-interleaved conversion core and the device output pins. Each cycle in which the core presents an 11-bit result with its strobe, the block folds the raw overrange indication and the result's top bit into one overrange flag. It forces the 10-bit code to all ones whenever that flag is set, registers the code and the flag on the rising clock edge, and raises a one-cycle data-valid strobe for that word.

The code bus is straight binary with bit 0 as the least significant bit. Because an overranged word reads as all ones plus a set flag, the flag acts as an extra most significant bit in a wider system. An active-low enable pin sets the code and flag pins to high impedance or lets them drive. It also drives a pad-enable control, and it acts without any clock edge.

Top module: `adcfmt_top`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `dvalid` is 0, and (with `oe_n` low) `dout` is 0 and `ovr` is 0.
- R2: On the rising edge where `res_vld` is 1, `res_word` is below 1024 and `ovr_raw` is 0, `dout` takes `res_word[9:0]` and `ovr` becomes 0. Both are visible after that edge.
- R3: On a rising edge where `res_vld` and `ovr_raw` are both 1, `ovr` becomes 1 and `dout` becomes 10'h3FF, whatever the value of `res_word`.
- R4: On a rising edge where `res_vld` is 1 and `res_word` is 1024 or more (bit 10 set), `ovr` becomes 1 and `dout` becomes 10'h3FF, even with `ovr_raw` low.
- R5: `dvalid` is 1 for exactly the one cycle after each edge with `res_vld` high, and is 0 after every edge with `res_vld` low, including the edges before the first result.
- R6: On an edge with `res_vld` low, `dout` and `ovr` keep their previous values, and `res_word` and `ovr_raw` are ignored.
- R7: While `oe_n` is 1, `dout` and `ovr` are high impedance and `pad_oe` is 0. The change takes effect without a clock edge. Results still load into the output register.
- R8: While `oe_n` is 0, `pad_oe` is 1 and `dout` and `ovr` drive the registered word. The change takes effect without a clock edge.
- R9: Whenever `ovr` is driven as 1, every bit of `dout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output register clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low pin enable |
| res_word | input | 11 | Result from the conversion core |
| res_vld | input | 1 | Result strobe from the core |
| ovr_raw | input | 1 | Raw overrange indication from the core |
| dout | output | 10 | Straight-binary code pins, tri-stated |
| ovr | output | 1 | Overrange pin, tri-stated |
| dvalid | output | 1 | One-cycle strobe per new word |
| pad_oe | output | 1 | Pad drive enable, active high |

## Verification
Two functions can act in the same cycle: the overrange clamp can capture a word while the pins are floating. The bench provokes this by loading an out-of-range result with `oe_n` high. It first confirms that the pins stay high impedance. It then lowers `oe_n` between clock edges and expects the clamped all-ones code with the flag set at once, with no edge in between. A second coincidence sends a raw overrange flag together with an in-range word and expects the clamp to win.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
    parameter int CODE_W = 10;
    localparam int CORE_W = CODE_W + 1;

    typedef struct packed {
        logic              over;
        logic [CODE_W-1:0] code;
    } fmt_word_t;

    // Fold both overrange sources into one flag; saturate the code when set.
    function automatic fmt_word_t fold_word(input logic [CORE_W-1:0] raw,
                                            input logic             ovr_in);
        fmt_word_t w;
        w.over = ovr_in | raw[CORE_W-1];
        w.code = w.over ? {CODE_W{1'b1}} : raw[CODE_W-1:0];
        return w;
    endfunction
endpackage

// File: rtl/adcfmt_clamp.sv
module adcfmt_clamp
    import adcfmt_pkg::*;
(
    input  logic [CORE_W-1:0] raw_word,
    input  logic              raw_ovr,
    output fmt_word_t         folded
);
    always_comb begin
        folded = fold_word(raw_word, raw_ovr);
    end
endmodule

// File: rtl/adcfmt_outreg.sv
module adcfmt_outreg
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              raw_top,
    input  fmt_word_t         d,
    output fmt_word_t         q,
    output logic              strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load;
            if (load) begin
                q <= d;
            end
        end
    end

    // R9
    ovr_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        q.over |-> (&q.code));

    // R4
    top_bit_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (load && raw_top) |=> (q.over && (&q.code)));

    // R5
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> strobe);

    // R5
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !strobe);

    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/adcfmt_padctl.sv
module adcfmt_padctl
    import adcfmt_pkg::*;
(
    input  logic              oe_n,
    input  fmt_word_t         q,
    output logic              pad_oe,
    output logic [CODE_W-1:0] code_pin,
    output logic              over_pin
);
    assign pad_oe = ~oe_n;

    for (genvar i = 0; i < CODE_W; i++) begin : g_code_pad
        assign code_pin[i] = pad_oe ? q.code[i] : 1'bz;
    end
    assign over_pin = pad_oe ? q.over : 1'bz;
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top
    import adcfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic [CORE_W-1:0] res_word,
    input  logic              res_vld,
    input  logic              ovr_raw,
    output logic [CODE_W-1:0] dout,
    output logic              ovr,
    output logic              dvalid,
    output logic              pad_oe
);
    fmt_word_t folded;
    fmt_word_t held;

    adcfmt_clamp u_clamp (
        .raw_word (res_word),
        .raw_ovr  (ovr_raw),
        .folded   (folded)
    );

    adcfmt_outreg u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (res_vld),
        .raw_top (res_word[CORE_W-1]),
        .d       (folded),
        .q       (held),
        .strobe  (dvalid)
    );

    adcfmt_padctl u_padctl (
        .oe_n     (oe_n),
        .q        (held),
        .pad_oe   (pad_oe),
        .code_pin (dout),
        .over_pin (ovr)
    );

    // R3
    raw_ovr_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && ovr_raw && !oe_n) ##1 !oe_n |-> (ovr === 1'b1) && (dout === {CODE_W{1'b1}}));
endmodule

// File: tb/adcfmt_top_bench.sv
module adcfmt_top_bench;
    localparam int CLK_P = 10;
    localparam int NV = 8;
    // {word[11], raw_ovr, exp_ovr, exp_code[10]}
    localparam logic [22:0] VEC [NV] = '{
        {11'h000, 1'b0, 1'b0, 10'h000},
        {11'h001, 1'b0, 1'b0, 10'h001},
        {11'h3FF, 1'b0, 1'b0, 10'h3FF},
        {11'h200, 1'b0, 1'b0, 10'h200},
        {11'h400, 1'b0, 1'b1, 10'h3FF},
        {11'h7FF, 1'b0, 1'b1, 10'h3FF},
        {11'h155, 1'b1, 1'b1, 10'h3FF},
        {11'h2AA, 1'b0, 1'b0, 10'h2AA}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oe_n = 1'b0;
    logic [10:0] res_word = '0;
    logic        res_vld = 1'b0;
    logic        ovr_raw = 1'b0;
    logic [9:0]  dout;
    logic        ovr;
    logic        dvalid;
    logic        pad_oe;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    adcfmt_top u_adcfmt_top (
        .clk(clk), .rst(rst), .oe_n(oe_n), .res_word(res_word),
        .res_vld(res_vld), .ovr_raw(ovr_raw), .dout(dout), .ovr(ovr),
        .dvalid(dvalid), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at falling edge, then let one rising edge pass and sample 1 time unit after it
    task automatic push(input logic [10:0] w, input logic r, input logic v);
        @(negedge clk);
        res_word = w; ovr_raw = r; res_vld = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 dvalid", {11'b0, dvalid}, 12'h000);
        chk("R1 word", {1'b0, ovr, dout}, 12'h000);
        @(negedge clk); rst = 1'b0;
        // R5 no strobe before the first result
        push(11'h123, 1'b1, 1'b0);
        chk("R5 idle before first", {11'b0, dvalid}, 12'h000);
        chk("R6 ignored before first", {1'b0, ovr, dout}, 12'h000);

        // vector table: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][22:12], VEC[i][11], 1'b1);
            chk("R2/R3/R4 word", {1'b0, ovr, dout}, {1'b0, VEC[i][10], VEC[i][9:0]});
            chk("R5 strobe", {11'b0, dvalid}, 12'h001);
        end

        // R6 hold with idle strobe and busy inputs
        push(11'h123, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            push(11'h0F0 + 11'(k), 1'b1, 1'b0);
            chk("R6 hold", {1'b0, ovr, dout}, 12'h123);
            chk("R5 single cycle", {11'b0, dvalid}, 12'h000);
        end

        // R7 tri-state without clock edge
        #2; oe_n = 1'b1; #1;
        chk("R7 dout z", {2'b0, (dout === 10'bz) ? 10'h001 : 10'h000}, 12'h001);
        chk("R7 ovr z", {11'b0, (ovr === 1'bz)}, 12'h001);
        chk("R7 pad_oe", {11'b0, pad_oe}, 12'h000);
        // same cycle: clamp while floating
        push(11'h500, 1'b0, 1'b1);
        chk("R7 still z", {11'b0, (dout === 10'bz)}, 12'h001);
        chk("R5 strobe while floating", {11'b0, dvalid}, 12'h001);
        #2; oe_n = 1'b0; #1;
        chk("R8 pad_oe", {11'b0, pad_oe}, 12'h001);
        chk("R8/R4 clamped word appears", {1'b0, ovr, dout}, 12'h7FF);
        // R9 flag implies all ones after raw overrange on small word
        push(11'h001, 1'b1, 1'b1);
        chk("R9 ones with flag", {1'b0, ovr, dout}, 12'h7FF);
        // recovery to in-range
        push(11'h0AB, 1'b0, 1'b1);
        chk("R2 recover", {1'b0, ovr, dout}, 12'h0AB);

        // R1 reset mid-stream
        @(negedge clk); rst = 1'b1; res_vld = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid reset word", {1'b0, ovr, dout}, 12'h000);
        chk("R1 mid reset dvalid", {11'b0, dvalid}, 12'h000);
        @(negedge clk); rst = 1'b0; res_vld = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule